// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Space Tags and Entry Locking

This block caches virtual-to-physical page mappings in eight fully associative slots. One copy serves instruction fetch and another serves data access. A lookup presents an effective address, the current address-space tag and the privilege level. In the same cycle, the block answers with a hit, the physical address and the protection group of the matching slot, or with a miss.

The block performs no table walk. On a miss it only raises the miss output, and software loads the mapping through a write port. Every slot holds its own page size, one of four. A slot can be shared across address spaces or restricted to supervisor code. Two maintenance commands remove mappings: one flushes all slots, and the other removes only the slots that cover a given address.

Slots written with the lock flag are skipped by the round-robin replacement pointer while the lock control input is high. When translation is turned off, addresses pass through unchanged.

Top module: `tlb_assoc`

## Requirements
- R1: With `xlat_en`=1, a lookup hits when a valid slot's virtual tag equals `lu_ea` above that slot's page offset. `lu_pa` is then the slot's physical frame bits above the offset joined with the `lu_ea` offset bits, and `lu_grp` is the slot's group. On a miss, `lu_hit`=0, `lu_pa`=0 and `lu_grp`=0. `lu_miss` is always the inverse of `lu_hit`, and the lookup path is combinational.
- R2: `wr_size` selects the page size of the written slot: 0 gives 4 KB (12 offset bits), 1 gives 16 KB (14), 2 gives 512 KB (19) and 3 gives 8 MB (23). Address bits below the offset are ignored when the slot is written and when it is matched.
- R3: A slot written with `wr_shared`=0 matches only when `lu_asid` equals its stored 4-bit tag. A slot written with `wr_shared`=1 matches for any `lu_asid`.
- R4: A slot written with `wr_sup`=1 matches only when `lu_priv`=1.
- R5: `inv_all`=1 at a clock edge makes every slot invalid and unlocked after that edge.
- R6: `inv_one`=1 at a clock edge invalidates and unlocks every valid slot whose tag matches `inv_ea` under its own page size, for any address-space tag and privilege. All other slots are untouched.
- R7: With `xlat_en`=0, `lu_hit`=1, `lu_pa`=`lu_ea` and `lu_grp`=0, whatever the slot contents.
- R8: A write fills the first slot, searching upward from the replacement pointer with wrap-around, that is not locked. A slot counts as locked only while `lock_en`=1. If every slot counts as locked, the slot at the pointer is filled. The pointer then becomes the filled index plus one, modulo 8.
- R9: When several slots match a lookup, the lowest-indexed one supplies `lu_pa` and `lu_grp`.
- R10: If commands arrive in the same cycle, `inv_all` wins over `inv_one`, and `inv_one` wins over `wr_en`. The losing commands are ignored.
- R11: After reset, every slot is invalid and unlocked and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlat_en | input | 1 | Translation enable; 0 passes addresses through |
| lock_en | input | 1 | Lets lock flags protect slots from replacement |
| lu_ea | input | 32 | Lookup effective address |
| lu_asid | input | 4 | Current address-space tag |
| lu_priv | input | 1 | 1 = supervisor access |
| lu_hit | output | 1 | Lookup hit (forced 1 when translation is off) |
| lu_miss | output | 1 | Lookup miss, for a software reload |
| lu_pa | output | 32 | Physical address |
| lu_grp | output | 4 | Protection group of the hit slot |
| wr_en | input | 1 | Load a new slot |
| wr_ea | input | 32 | Virtual address of the new page |
| wr_pa | input | 32 | Physical address of the new page |
| wr_size | input | 2 | Page size code |
| wr_asid | input | 4 | Address-space tag of the new slot |
| wr_shared | input | 1 | Slot matches every address space |
| wr_sup | input | 1 | Slot is for supervisor access only |
| wr_grp | input | 4 | Protection group of the new slot |
| wr_lock | input | 1 | Lock flag of the new slot |
| inv_all | input | 1 | Flush all slots |
| inv_one | input | 1 | Flush the slots that cover `inv_ea` |
| inv_ea | input | 32 | Address for the single flush |

## Verification
The bound checker watches four things on every cycle:
- the pass-through result while translation is off;
- the empty, unlocked state that follows a flush;
- the survival of locked slots across a write;
- the filling of the chosen victim slot and the pointer step after it.

Page-size masking, address-space and privilege filtering, lowest-index selection and targeted flushes depend on what software wrote earlier. Only the bench's scenarios can show these. They are compared against a reference table that the bench keeps itself, over sweeps of all four page sizes at their offset edges and of all sixteen address-space tags.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    parameter int unsigned TLB_AW     = 32;
    parameter int unsigned TLB_ASID_W = 4;
    parameter int unsigned TLB_GRP_W  = 4;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_16K  = 2'd1,
        PG_512K = 2'd2,
        PG_8M   = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic                  valid;
        logic                  locked;
        logic                  shared;
        logic                  sup_only;
        logic [TLB_ASID_W-1:0] asid;
        logic [TLB_GRP_W-1:0]  grp;
        logic [TLB_AW-1:0]     off_mask;
        logic [TLB_AW-1:0]     vtag;
        logic [TLB_AW-1:0]     ptag;
    } tlb_ent_t;

    // Low bits set for the page offset of the given size.
    function automatic logic [TLB_AW-1:0] size_mask(pg_size_e sz);
        logic [TLB_AW-1:0] m;
        case (sz)
            PG_4K:   m = (TLB_AW'(1) << 12) - TLB_AW'(1);
            PG_16K:  m = (TLB_AW'(1) << 14) - TLB_AW'(1);
            PG_512K: m = (TLB_AW'(1) << 19) - TLB_AW'(1);
            default: m = (TLB_AW'(1) << 23) - TLB_AW'(1);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tlb_ent_t              ent,
    input  logic [TLB_AW-1:0]     ea,
    input  logic [TLB_ASID_W-1:0] asid,
    input  logic                  chk_ctx,
    input  logic                  priv,
    output logic                  hit
);

    logic tag_eq;
    logic ctx_ok;

    always_comb begin
        tag_eq = (((ea ^ ent.vtag) & ~ent.off_mask) == '0);
        ctx_ok = (ent.shared || (ent.asid == asid)) && (!ent.sup_only || priv);
        hit    = ent.valid && tag_eq && (!chk_ctx || ctx_ok);
    end

endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int unsigned N  = 8,
    parameter int unsigned PW = $clog2(N)
) (
    input  logic [N-1:0]  held,
    input  logic [PW-1:0] ptr,
    output logic [PW-1:0] victim
);

    logic          found;
    logic [PW-1:0] probe;

    always_comb begin
        victim = ptr;
        found  = 1'b0;
        probe  = ptr;
        for (int k = 0; k < N; k++) begin
            probe = ptr + PW'(k);
            if (!found && !held[probe]) begin
                victim = probe;
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
    import tlb_pkg::*;
#(
    parameter int unsigned N_ENT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xlat_en,
    input  logic                  lock_en,
    input  logic [TLB_AW-1:0]     lu_ea,
    input  logic [TLB_ASID_W-1:0] lu_asid,
    input  logic                  lu_priv,
    output logic                  lu_hit,
    output logic                  lu_miss,
    output logic [TLB_AW-1:0]     lu_pa,
    output logic [TLB_GRP_W-1:0]  lu_grp,
    input  logic                  wr_en,
    input  logic [TLB_AW-1:0]     wr_ea,
    input  logic [TLB_AW-1:0]     wr_pa,
    input  logic [1:0]            wr_size,
    input  logic [TLB_ASID_W-1:0] wr_asid,
    input  logic                  wr_shared,
    input  logic                  wr_sup,
    input  logic [TLB_GRP_W-1:0]  wr_grp,
    input  logic                  wr_lock,
    input  logic                  inv_all,
    input  logic                  inv_one,
    input  logic [TLB_AW-1:0]     inv_ea
);

    localparam int unsigned PW = $clog2(N_ENT);

    typedef struct packed {
        tlb_ent_t [N_ENT-1:0] ent;
        logic [PW-1:0]        ptr;
    } state_t;

    state_t st_d, st_q;

    logic [N_ENT-1:0] lu_vec;
    logic [N_ENT-1:0] inv_vec;
    logic [N_ENT-1:0] held_vec;
    logic [N_ENT-1:0] valid_vec;
    logic [N_ENT-1:0] lock_vec;
    logic             any_hit;
    logic [PW-1:0]    hit_idx;
    logic [PW-1:0]    victim;
    tlb_ent_t         sel;
    tlb_ent_t         new_ent;
    logic [TLB_AW-1:0] new_mask;

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        tlb_match u_lu (
            .ent     (st_q.ent[g]),
            .ea      (lu_ea),
            .asid    (lu_asid),
            .chk_ctx (1'b1),
            .priv    (lu_priv),
            .hit     (lu_vec[g])
        );
        tlb_match u_inv (
            .ent     (st_q.ent[g]),
            .ea      (inv_ea),
            .asid    ('0),
            .chk_ctx (1'b0),
            .priv    (1'b0),
            .hit     (inv_vec[g])
        );
        assign valid_vec[g] = st_q.ent[g].valid;
        assign lock_vec[g]  = st_q.ent[g].locked;
        assign held_vec[g]  = lock_en && st_q.ent[g].locked;
    end

    tlb_first #(.N(N_ENT), .IW(PW)) u_first (
        .req (lu_vec),
        .any (any_hit),
        .idx (hit_idx)
    );

    tlb_victim #(.N(N_ENT), .PW(PW)) u_victim (
        .held   (held_vec),
        .ptr    (st_q.ptr),
        .victim (victim)
    );

    // Lookup path
    always_comb begin
        sel = st_q.ent[hit_idx];
        if (!xlat_en) begin
            lu_hit = 1'b1;
            lu_pa  = lu_ea;
            lu_grp = '0;
        end else if (any_hit) begin
            lu_hit = 1'b1;
            lu_pa  = (sel.ptag & ~sel.off_mask) | (lu_ea & sel.off_mask);
            lu_grp = sel.grp;
        end else begin
            lu_hit = 1'b0;
            lu_pa  = '0;
            lu_grp = '0;
        end
        lu_miss = !lu_hit;
    end

    // Next state
    always_comb begin
        new_mask         = size_mask(pg_size_e'(wr_size));
        new_ent.valid    = 1'b1;
        new_ent.locked   = wr_lock;
        new_ent.shared   = wr_shared;
        new_ent.sup_only = wr_sup;
        new_ent.asid     = wr_asid;
        new_ent.grp      = wr_grp;
        new_ent.off_mask = new_mask;
        new_ent.vtag     = wr_ea & ~new_mask;
        new_ent.ptag     = wr_pa & ~new_mask;

        st_d = st_q;
        if (inv_all) begin
            for (int i = 0; i < N_ENT; i++) begin
                st_d.ent[i].valid  = 1'b0;
                st_d.ent[i].locked = 1'b0;
            end
        end else if (inv_one) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (inv_vec[i]) begin
                    st_d.ent[i].valid  = 1'b0;
                    st_d.ent[i].locked = 1'b0;
                end
            end
        end else if (wr_en) begin
            st_d.ent[victim] = new_ent;
            st_d.ptr         = victim + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk
    import tlb_pkg::*;
#(
    parameter int unsigned N_ENT = 8,
    parameter int unsigned PW    = $clog2(N_ENT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xlat_en,
    input logic              lock_en,
    input logic [TLB_AW-1:0] lu_ea,
    input logic              lu_hit,
    input logic [TLB_AW-1:0] lu_pa,
    input logic              wr_en,
    input logic              inv_all,
    input logic              inv_one,
    input logic [N_ENT-1:0]  valid_vec,
    input logic [N_ENT-1:0]  lock_vec,
    input logic [PW-1:0]     victim,
    input logic [PW-1:0]     ptr
);

    // R7: translation off passes the address through with a hit
    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_en |-> (lu_hit && (lu_pa == lu_ea)));

    // R5: a flush leaves nothing valid or locked
    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> ((valid_vec == '0) && (lock_vec == '0)));

    // R8: locked slots survive a write while some slot is free
    p_lock_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_en && wr_en && !inv_all && !inv_one && !(&lock_vec))
        |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec)));

    // R8: the chosen slot is filled
    p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inv_all && !inv_one) |=> valid_vec[$past(victim)]);

    // R8: the pointer steps past the filled slot
    p_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inv_all && !inv_one) |=> (ptr == PW'($past(victim) + 1'b1)));

endmodule

bind tlb_assoc tlb_assoc_chk #(.N_ENT(N_ENT)) u_tlb_assoc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xlat_en   (xlat_en),
    .lock_en   (lock_en),
    .lu_ea     (lu_ea),
    .lu_hit    (lu_hit),
    .lu_pa     (lu_pa),
    .wr_en     (wr_en),
    .inv_all   (inv_all),
    .inv_one   (inv_one),
    .valid_vec (valid_vec),
    .lock_vec  (lock_vec),
    .victim    (victim),
    .ptr       (st_q.ptr)
);

// File: tb/test_tlb_assoc.sv
module test_tlb_assoc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b1, lock_en = 1'b0;
    logic [31:0] lu_ea = '0;
    logic [3:0]  lu_asid = '0;
    logic        lu_priv = 1'b0;
    logic        lu_hit, lu_miss;
    logic [31:0] lu_pa;
    logic [3:0]  lu_grp;
    logic        wr_en = 1'b0;
    logic [31:0] wr_ea = '0, wr_pa = '0;
    logic [1:0]  wr_size = '0;
    logic [3:0]  wr_asid = '0;
    logic        wr_shared = 1'b0, wr_sup = 1'b0;
    logic [3:0]  wr_grp = '0;
    logic        wr_lock = 1'b0;
    logic        inv_all = 1'b0, inv_one = 1'b0;
    logic [31:0] inv_ea = '0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference table
    bit          m_valid [8];
    bit          m_lock  [8];
    bit          m_sh    [8];
    bit          m_sup   [8];
    logic [31:0] m_vtag  [8];
    logic [31:0] m_ptag  [8];
    logic [31:0] m_mask  [8];
    logic [3:0]  m_asid  [8];
    logic [3:0]  m_grp   [8];
    int          m_ptr = 0;

    always #4 clk = ~clk;

    tlb_assoc i_tlb_assoc (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .lock_en(lock_en),
        .lu_ea(lu_ea), .lu_asid(lu_asid), .lu_priv(lu_priv),
        .lu_hit(lu_hit), .lu_miss(lu_miss), .lu_pa(lu_pa), .lu_grp(lu_grp),
        .wr_en(wr_en), .wr_ea(wr_ea), .wr_pa(wr_pa), .wr_size(wr_size),
        .wr_asid(wr_asid), .wr_shared(wr_shared), .wr_sup(wr_sup),
        .wr_grp(wr_grp), .wr_lock(wr_lock),
        .inv_all(inv_all), .inv_one(inv_one), .inv_ea(inv_ea)
    );

    function automatic logic [31:0] mk(int sz);
        int b;
        case (sz)
            0: b = 12;
            1: b = 14;
            2: b = 19;
            default: b = 23;
        endcase
        return (32'd1 << b) - 32'd1;
    endfunction

    function automatic bit tag_eq(logic [31:0] ea, int i);
        return ((ea ^ m_vtag[i]) & ~m_mask[i]) == 32'd0;
    endfunction

    task automatic model_flush();
        for (int i = 0; i < 8; i++) begin
            m_valid[i] = 0;
            m_lock[i] = 0;
        end
    endtask

    task automatic chk(input logic [31:0] ea, input logic [3:0] asid, input logic pv,
                       input string tag);
        logic eh;
        logic [31:0] ep;
        logic [3:0] eg;
        @(negedge clk);
        lu_ea = ea; lu_asid = asid; lu_priv = pv;
        #1;
        eh = 0; ep = '0; eg = '0;
        if (!xlat_en) begin
            eh = 1; ep = ea;
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (!eh && m_valid[i] && tag_eq(ea, i) &&
                    (m_sh[i] || m_asid[i] == asid) && (!m_sup[i] || pv)) begin
                    eh = 1;
                    ep = (m_ptag[i] & ~m_mask[i]) | (ea & m_mask[i]);
                    eg = m_grp[i];
                end
            end
        end
        n_run++;
        if (lu_hit !== eh || lu_miss !== !eh || lu_pa !== ep || lu_grp !== eg) begin
            n_fail++;
            $display("FAIL %s: ea=%h asid=%0d priv=%b got hit=%b miss=%b pa=%h grp=%h exp hit=%b pa=%h grp=%h",
                     tag, ea, asid, pv, lu_hit, lu_miss, lu_pa, lu_grp, eh, ep, eg);
        end
    endtask

    // drive one cycle of commands; reference follows the priority of R10
    task automatic cmd(input bit ia, input bit io, input logic [31:0] iea, input bit we,
                       input logic [31:0] ea, input logic [31:0] pa, input int sz,
                       input logic [3:0] asid, input bit sh, input bit sp,
                       input logic [3:0] g, input bit lk);
        int v;
        logic [31:0] m;
        @(negedge clk);
        inv_all = ia; inv_one = io; inv_ea = iea;
        wr_en = we; wr_ea = ea; wr_pa = pa; wr_size = 2'(sz); wr_asid = asid;
        wr_shared = sh; wr_sup = sp; wr_grp = g; wr_lock = lk;
        if (ia) begin
            model_flush();
        end else if (io) begin
            for (int i = 0; i < 8; i++)
                if (m_valid[i] && tag_eq(iea, i)) begin
                    m_valid[i] = 0;
                    m_lock[i] = 0;
                end
        end else if (we) begin
            v = m_ptr;
            for (int k = 7; k >= 0; k--) begin
                if (!(lock_en && m_lock[(m_ptr + k) % 8])) v = (m_ptr + k) % 8;
            end
            m = mk(sz);
            m_valid[v] = 1; m_lock[v] = lk; m_sh[v] = sh; m_sup[v] = sp;
            m_mask[v] = m; m_vtag[v] = ea & ~m; m_ptag[v] = pa & ~m;
            m_asid[v] = asid; m_grp[v] = g;
            m_ptr = (v + 1) % 8;
        end
        @(posedge clk);
        #1;
        inv_all = 0; inv_one = 0; wr_en = 0;
    endtask

    task automatic wr(input logic [31:0] ea, input logic [31:0] pa, input int sz,
                      input logic [3:0] asid, input bit sh, input bit sp,
                      input logic [3:0] g, input bit lk);
        cmd(0, 0, '0, 1, ea, pa, sz, asid, sh, sp, g, lk);
    endtask

    // lookups covering the slot bases written by fill()
    task automatic sweep(input string tag);
        for (int k = 0; k < 8; k++) begin
            logic [31:0] base;
            logic [31:0] m;
            base = 32'(k) << 25;
            m = mk(k % 4);
            for (int a = 0; a < 16; a++) begin
                chk(base, 4'(a), 1'b0, tag);
                chk(base | m, 4'(a), 1'b1, tag);
            end
            chk(base + m + 32'd1, 4'(k), 1'b1, tag);
            chk(base | 32'h0000_0abc, 4'(k), 1'b1, tag);
        end
    endtask

    task automatic fill(input bit lk);
        for (int k = 0; k < 8; k++)
            wr((32'(k) << 25) | 32'h0000_0777, 32'hc000_0000 ^ (32'(k) << 24) ^ 32'h0000_0fff,
               k % 4, 4'(k), k == 7, k == 6, 4'(k + 3), lk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        model_flush();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: empty after reset
        for (int a = 0; a < 8; a++) chk(32'h1234_5000 * 32'(a), 4'(a), 1'b1, "R11 reset");

        // R7: bypass
        xlat_en = 1'b0;
        for (int a = 0; a < 16; a++) chk(32'h1111_1111 * 32'(a) ^ 32'h0f0f_0000, 4'(a), a[0], "R7 bypass");
        xlat_en = 1'b1;

        // R1 R2 R3 R4: all sizes, all spaces, both privileges
        fill(0);
        sweep("R1 R2 R3 R4 sweep");

        // R8: pointer wrapped to slot 0, which is replaced
        wr(32'h8000_0000, 32'h0123_4000, 0, 4'd1, 0, 0, 4'd9, 0);
        chk(32'h0000_0010, 4'd0, 1'b1, "R8 slot0 replaced");
        chk(32'h8000_0abc, 4'd1, 1'b0, "R8 new slot");

        // R9: overlapping 8MB and 4KB pages, lowest index wins
        wr(32'h9000_0000, 32'h4000_0000, 3, 4'd2, 0, 0, 4'd10, 0);
        wr(32'h9000_0000, 32'h5550_0000, 0, 4'd2, 0, 0, 4'd11, 0);
        chk(32'h9000_0123, 4'd2, 1'b0, "R9 lowest wins");
        chk(32'h9000_1000, 4'd2, 1'b0, "R9 large only");

        // R6: targeted flush drops both covering slots, others stay
        cmd(0, 1, 32'h9000_0200, 0, '0, '0, 0, '0, 0, 0, '0, 0);
        chk(32'h9000_0123, 4'd2, 1'b0, "R6 flushed");
        sweep("R6 others kept");

        // R5: full flush
        cmd(1, 0, '0, 0, '0, '0, 0, '0, 0, 0, '0, 0);
        sweep("R5 flushed");

        // R8: locked slots survive rotation
        lock_en = 1'b1;
        for (int k = 0; k < 3; k++)
            wr(32'ha000_0000 + (32'(k) << 12), 32'h0700_0000 + (32'(k) << 12), 0, 4'd5, 0, 0, 4'(k), 1);
        for (int k = 0; k < 12; k++)
            wr(32'hb000_0000 + (32'(k) << 12), 32'h0800_0000 + (32'(k) << 12), 0, 4'd5, 1, 0, 4'(k), 0);
        for (int k = 0; k < 3; k++) chk(32'ha000_0040 + (32'(k) << 12), 4'd5, 1'b0, "R8 locked kept");
        for (int k = 0; k < 12; k++) chk(32'hb000_0040 + (32'(k) << 12), 4'd3, 1'b0, "R8 rotation");

        // R8: lock ignored while lock_en is low
        lock_en = 1'b0;
        for (int k = 0; k < 4; k++)
            wr(32'hd000_0000 + (32'(k) << 12), 32'h0900_0000, 1, 4'd6, 0, 0, 4'd7, 0);
        for (int k = 0; k < 3; k++) chk(32'ha000_0040 + (32'(k) << 12), 4'd5, 1'b0, "R8 lock off");

        // R8: all locked, write lands at pointer
        lock_en = 1'b1;
        cmd(1, 0, '0, 0, '0, '0, 0, '0, 0, 0, '0, 0);
        for (int k = 0; k < 8; k++)
            wr(32'he000_0000 + (32'(k) << 14), 32'h0a00_0000 + (32'(k) << 14), 1, 4'd4, 0, 0, 4'(k), 1);
        wr(32'hf000_0000, 32'h0b00_0000, 2, 4'd4, 0, 0, 4'd15, 0);
        for (int k = 0; k < 8; k++) chk(32'he000_0010 + (32'(k) << 14), 4'd4, 1'b0, "R8 all locked");
        chk(32'hf000_1234, 4'd4, 1'b0, "R8 all locked new");
        lock_en = 1'b0;

        // R10: command priority
        cmd(1, 1, 32'he000_0000, 1, 32'h7000_0000, 32'h0c00_0000, 0, 4'd1, 0, 0, 4'd1, 0);
        chk(32'h7000_0000, 4'd1, 1'b0, "R10 flush beats write");
        chk(32'he000_4010, 4'd4, 1'b0, "R10 flush all");
        wr(32'h6000_0000, 32'h0d00_0000, 0, 4'd1, 0, 0, 4'd2, 0);
        cmd(0, 1, 32'h6000_0000, 1, 32'h5000_0000, 32'h0e00_0000, 0, 4'd1, 0, 0, 4'd3, 0);
        chk(32'h6000_0000, 4'd1, 1'b0, "R10 single flush");
        chk(32'h5000_0000, 4'd1, 1'b0, "R10 write ignored");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule